// File: doc/BRIEF.md
# I2C controller status flag register

This block is the byte-wide status register of a two-wire bus controller that can work as bus master or as slave. The bus engine reports events to it as single-cycle strobes: an address phase that finished, a ninth clock with no acknowledge, a bus error, a byte ready in the data register, and a stop condition. The register turns these strobes into sticky flags. It decodes CPU writes with write-one-to-clear rules. It turns data-register accesses into clears of the data-ready flag. It drives an interrupt request and a request to hold the clock line low.

The stall flag lets software step in between the address phase and the first data byte. While the flag is set, the clock is held low. The data-ready flag survives a data read while a start request is pending, so a repeated start can be issued in master receive mode. When the module is disabled, every flag is cleared and held at zero. The bit engine, the data register and the address decode are outside this block. The decode appears here only as select strobes.

Top module: `i2c_stat_reg`

## Requirements
- R1: While reset is low and after it is released, every status bit reads 0, and `irq` and `scl_hold` are 0.
- R2: The status byte carries the stall flag in bit 3, missing-acknowledge in bit 4, bus error in bit 5, data-ready in bit 6 and slave-stop in bit 7. Bits 2:0 always read 0.
- R3: After a clock edge at which `ev_addr_sent`, `is_master` and `stall_en` are 1 and `ev_nak` and `ev_berr` are 0, the stall flag is 1. It is not set in slave mode. `scl_hold` is 1 exactly while the stall flag is 1.
- R4: A status write (`cpu_wr` and `cpu_sel_stat`) clears each of bits 3, 4, 5 and 7 whose write-data bit is 1. A 0 in a bit leaves that bit unchanged. Writing bit 6 has no effect.
- R5: `ev_nak` sets the missing-acknowledge flag. When `ev_byte_done` arrives in the same cycle as `ev_nak`, the data-ready flag is not set.
- R6: While `mod_en` is 0, every flag is cleared one edge later and stays 0, and event strobes have no effect.
- R7: While `stall_en` is 0, the stall flag is 0 from the next edge on.
- R8: `ev_byte_done` sets data-ready. A data read (`cpu_rd` and `cpu_sel_data`) with `xmit_mode`=0 clears it, unless `start_req` is 1. A data write with `xmit_mode`=1 clears it. A data read in transmit mode and a data write in receive mode leave it unchanged.
- R9: `ev_stop` sets slave-stop only if `slv_match` was 1 at some edge since the previous stop, or is 1 in the same cycle. A stop after a transfer with no match leaves the flag at 0.
- R10: `irq` is 1 when `irq_en` is 1 and at least one flag is set, and 0 otherwise. When a set event and a write-one-to-clear of the same flag fall in one cycle, the flag ends up set.
- R11: `ev_berr` sets the bus-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Module enable; 0 clears and holds all flags |
| irq_en | input | 1 | Interrupt enable |
| stall_en | input | 1 | Enables the stall-after-address flag |
| start_req | input | 1 | Start request pending; stops data reads from clearing data-ready |
| is_master | input | 1 | Controller is in master mode |
| xmit_mode | input | 1 | 1 = transmit, 0 = receive |
| ev_addr_sent | input | 1 | Strobe: start and address byte sent |
| ev_nak | input | 1 | Strobe: no acknowledge on the ninth clock |
| ev_berr | input | 1 | Strobe: bus error |
| ev_byte_done | input | 1 | Strobe: data register ready |
| ev_stop | input | 1 | Strobe: stop condition seen |
| slv_match | input | 1 | Level: address or general-call match in slave mode |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_sel_stat | input | 1 | Access targets the status register |
| cpu_sel_data | input | 1 | Access targets the data register |
| cpu_wdata | input | 8 | CPU write data |
| stat_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold the clock line low |

## Verification
Every flag changes at the first clock edge after the strobe, CPU access or enable change that affects it, because that edge loads the flag register. `irq` and `scl_hold` are combinational from the flags, so they are due in the same cycle as the flag. The driver applies each stimulus just after a falling edge and queues the result that is due after the next rising edge. The monitor pops that item one time unit after the rising edge, so each comparison falls exactly one edge after its stimulus. Same-cycle collisions are placed in single stimulus cycles: a set together with a clear, a missing acknowledge together with a ready byte, and a stop together with a match.

// File: rtl/i2c_stat_pkg.sv
// Package: shared constants for the status flag register.
// Flag index i maps to status bit FLAG_LSB + i; the bit positions are
// fixed because software decodes them.
package i2c_stat_pkg;
    localparam int NFLAG    = 5;
    localparam int FLAG_LSB = 3;
    localparam int STAT_W   = FLAG_LSB + NFLAG;

    // flag indices
    localparam int F_STALL = 0;
    localparam int F_NAK   = 1;
    localparam int F_BERR  = 2;
    localparam int F_DRDY  = 3;
    localparam int F_SSTOP = 4;

    // flags clearable by writing 1 to the status register
    localparam logic [NFLAG-1:0] W1C_MASK = 5'b10111;
endpackage

// File: rtl/stat_event_qual.sv
// Module: stat_event_qual
// Turns raw bus-engine strobes into per-flag set requests.
// Assumes strobes are one cycle wide and slv_match is a level that the
// engine holds for the duration of a matched slave transfer.
module stat_event_qual
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             stall_en,
    input  logic             is_master,
    input  logic             ev_addr_sent,
    input  logic             ev_nak,
    input  logic             ev_berr,
    input  logic             ev_byte_done,
    input  logic             ev_stop,
    input  logic             slv_match,
    output logic [NFLAG-1:0] set_vec
);
    logic match_seen;

    // Remembers that the current transfer was a matched slave transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !mod_en) begin
            match_seen <= 1'b0;
        end else if (ev_stop) begin
            match_seen <= 1'b0;
        end else if (slv_match) begin
            match_seen <= 1'b1;
        end
    end

    // Qualifies each strobe into a set request for its flag.
    always_comb begin
        set_vec          = '0;
        set_vec[F_STALL] = ev_addr_sent && is_master && stall_en && !ev_nak && !ev_berr;
        set_vec[F_NAK]   = ev_nak;
        set_vec[F_BERR]  = ev_berr;
        set_vec[F_DRDY]  = ev_byte_done && !ev_nak;
        set_vec[F_SSTOP] = ev_stop && (match_seen || slv_match);
    end
endmodule

// File: rtl/stat_clear_dec.sv
// Module: stat_clear_dec
// Decodes CPU accesses and control levels into per-flag clear and
// force-clear requests. Purely combinational.
// Assumes at most one of cpu_sel_stat / cpu_sel_data is active at a time.
module stat_clear_dec
    import i2c_stat_pkg::*;
(
    input  logic              mod_en,
    input  logic              stall_en,
    input  logic              start_req,
    input  logic              xmit_mode,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_sel_stat,
    input  logic              cpu_sel_data,
    input  logic [STAT_W-1:0] cpu_wdata,
    output logic [NFLAG-1:0]  clr_vec,
    output logic [NFLAG-1:0]  frc_vec
);
    logic wr_stat;
    logic drdy_rd_clr;
    logic drdy_wr_clr;
    logic unused_wbits;

    assign wr_stat      = cpu_wr && cpu_sel_stat;
    assign drdy_rd_clr  = cpu_rd && cpu_sel_data && !xmit_mode && !start_req;
    assign drdy_wr_clr  = cpu_wr && cpu_sel_data && xmit_mode;
    assign unused_wbits = ^cpu_wdata[FLAG_LSB-1:0];

    // One clear term per flag: write-one-to-clear or data-register access.
    for (genvar i = 0; i < NFLAG; i++) begin : g_clr
        if (W1C_MASK[i]) begin : g_w1c
            assign clr_vec[i] = wr_stat && cpu_wdata[FLAG_LSB+i];
        end else begin : g_data
            assign clr_vec[i] = drdy_rd_clr || drdy_wr_clr;
        end
    end

    // Force-clear: disable clears everything; stall-enable gates the stall flag.
    always_comb begin
        frc_vec          = {NFLAG{!mod_en}};
        frc_vec[F_STALL] = !mod_en || !stall_en;
    end
endmodule

// File: rtl/stat_flag_bank.sv
// Module: stat_flag_bank
// A bank of sticky flags. Per flag the priority is force-clear, then set,
// then clear, then hold. Set winning over clear is intentional.
module stat_flag_bank
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    input  logic [NFLAG-1:0] frc_vec,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_cell
        // Updates one flag with force > set > clear > hold priority.
        always_ff @(posedge clk) begin
            if (!rst_n || frc_vec[i]) begin
                flags[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_stat_reg.sv
// Module: i2c_stat_reg (top)
// Status flag register of a two-wire bus controller: collects engine
// events into sticky flags, applies CPU write-one-to-clear and data
// access clears, and drives the interrupt and clock-hold requests.
// Assumes a synchronous active-low reset and single-cycle event strobes.
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              irq_en,
    input  logic              stall_en,
    input  logic              start_req,
    input  logic              is_master,
    input  logic              xmit_mode,
    input  logic              ev_addr_sent,
    input  logic              ev_nak,
    input  logic              ev_berr,
    input  logic              ev_byte_done,
    input  logic              ev_stop,
    input  logic              slv_match,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_sel_stat,
    input  logic              cpu_sel_data,
    input  logic [STAT_W-1:0] cpu_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq,
    output logic              scl_hold
);
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] frc_vec;
    logic [NFLAG-1:0] flags;

    stat_event_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_en       (mod_en),
        .stall_en     (stall_en),
        .is_master    (is_master),
        .ev_addr_sent (ev_addr_sent),
        .ev_nak       (ev_nak),
        .ev_berr      (ev_berr),
        .ev_byte_done (ev_byte_done),
        .ev_stop      (ev_stop),
        .slv_match    (slv_match),
        .set_vec      (set_vec)
    );

    stat_clear_dec u_dec (
        .mod_en       (mod_en),
        .stall_en     (stall_en),
        .start_req    (start_req),
        .xmit_mode    (xmit_mode),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_sel_stat (cpu_sel_stat),
        .cpu_sel_data (cpu_sel_data),
        .cpu_wdata    (cpu_wdata),
        .clr_vec      (clr_vec),
        .frc_vec      (frc_vec)
    );

    stat_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .frc_vec (frc_vec),
        .flags   (flags)
    );

    // Status byte: flags in the upper bits, reserved low bits read zero.
    assign stat_rdata = {flags, {FLAG_LSB{1'b0}}};
    // Interrupt request: any set flag, gated by the enable.
    assign irq        = irq_en && (|flags);
    // Clock hold follows the stall flag.
    assign scl_hold   = flags[F_STALL];
endmodule

// File: rtl/i2c_stat_reg_chk.sv
// Module: i2c_stat_reg_chk
// Assertion checker bound to i2c_stat_reg. Observes ports only.
module i2c_stat_reg_chk
    import i2c_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mod_en,
    input logic              irq_en,
    input logic              stall_en,
    input logic              is_master,
    input logic              ev_addr_sent,
    input logic              ev_nak,
    input logic              ev_berr,
    input logic              cpu_wr,
    input logic              cpu_sel_stat,
    input logic [STAT_W-1:0] cpu_wdata,
    input logic [STAT_W-1:0] stat_rdata,
    input logic              irq,
    input logic              scl_hold
);
    logic unused_chk;
    assign unused_chk = ^{cpu_wdata[3:0], cpu_wdata[7:6], stat_rdata[2:0]};

    // R3: a rising stall flag needs a qualified master address event.
    p_stall_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[3]) |-> $past(ev_addr_sent && is_master && stall_en));

    // R3: the clock is never held without the stall flag.
    p_hold_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> stat_rdata[3]);

    // R4: writing 1 to the bus-error bit clears it when no new error arrives.
    p_w1c_berr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_wr && cpu_sel_stat && cpu_wdata[5] && !ev_berr) |-> !stat_rdata[5]);

    // R6: after a disabled cycle every flag is zero.
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mod_en) |-> (stat_rdata[7:3] == '0));

    // R7: stall-enable low clears the stall flag.
    p_stall_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!stall_en) |-> !scl_hold);

    // R10: set wins over a simultaneous clear.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mod_en && ev_nak) |-> stat_rdata[4]);

    // R10: no interrupt while disabled.
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (.*);

// File: tb/sim_i2c_stat_reg.sv
// Scoreboard bench for i2c_stat_reg: the driver queues expected results,
// the monitor compares them one edge after each stimulus.
module sim_i2c_stat_reg;
    localparam int CLK_PER = 10;
    localparam int WD_CYC  = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mod_en, irq_en, stall_en, start_req, is_master, xmit_mode;
    logic       ev_addr_sent, ev_nak, ev_berr, ev_byte_done, ev_stop, slv_match;
    logic       cpu_wr, cpu_rd, cpu_sel_stat, cpu_sel_data;
    logic [7:0] cpu_wdata;
    logic [7:0] stat_rdata;
    logic       irq, scl_hold;

    typedef struct {
        logic [7:0] st;
        logic       irq;
        logic       hold;
        string      tag;
    } exp_t;

    exp_t     sb[$];
    int       total = 0;
    int       bad   = 0;
    logic [4:0] m_fl;
    logic       m_seen;

    always #(CLK_PER/2) clk = ~clk;

    i2c_stat_reg u0 (.*);

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: models the next flag state from the requirements and queues it.
    task automatic cyc(input string tag);
        logic [4:0] s, c, n;
        logic ws;
        ws   = cpu_wr && cpu_sel_stat;
        s[0] = is_master && ev_addr_sent && stall_en && !ev_nak && !ev_berr;
        s[1] = ev_nak;
        s[2] = ev_berr;
        s[3] = ev_byte_done && !ev_nak;
        s[4] = ev_stop && (m_seen || slv_match);
        c[0] = ws && cpu_wdata[3];
        c[1] = ws && cpu_wdata[4];
        c[2] = ws && cpu_wdata[5];
        c[3] = cpu_sel_data && ((cpu_rd && !xmit_mode && !start_req) || (cpu_wr && xmit_mode));
        c[4] = ws && cpu_wdata[7];
        for (int i = 0; i < 5; i++) n[i] = s[i] ? 1'b1 : (c[i] ? 1'b0 : m_fl[i]);
        if (!stall_en) n[0] = 1'b0;
        if (!mod_en) n = '0;
        if (!mod_en || ev_stop) m_seen = 1'b0;
        else if (slv_match) m_seen = 1'b1;
        m_fl = n;
        sb.push_back('{st: {n, 3'b000}, irq: irq_en && (|n), hold: n[0], tag: tag});
        @(negedge clk);
        ev_addr_sent = 0; ev_nak = 0; ev_berr = 0; ev_byte_done = 0; ev_stop = 0;
        cpu_wr = 0; cpu_rd = 0; cpu_sel_stat = 0; cpu_sel_data = 0; cpu_wdata = '0;
    endtask

    task automatic wr_stat(input logic [7:0] d, input string tag);
        cpu_wr = 1; cpu_sel_stat = 1; cpu_wdata = d;
        cyc(tag);
    endtask

    // Monitor: compares one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "stat", stat_rdata, e.st);
                chk(e.tag, "irq", {7'b0, irq}, {7'b0, e.irq});
                chk(e.tag, "scl_hold", {7'b0, scl_hold}, {7'b0, e.hold});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYC) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; mod_en = 0; irq_en = 0; stall_en = 0; start_req = 0;
        is_master = 0; xmit_mode = 0; slv_match = 0;
        ev_addr_sent = 0; ev_nak = 0; ev_berr = 0; ev_byte_done = 0; ev_stop = 0;
        cpu_wr = 0; cpu_rd = 0; cpu_sel_stat = 0; cpu_sel_data = 0; cpu_wdata = '0;
        m_fl = '0; m_seen = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "stat", stat_rdata, 8'h00);
        chk("R1", "irq/hold", {6'b0, irq, scl_hold}, 8'h00);
        rst_n = 1; mod_en = 1; irq_en = 1; stall_en = 1;
        cyc("R1");

        // R11, R2: bus error lands in bit 5
        ev_berr = 1; cyc("R11");
        // R4: writing zeros changes nothing
        wr_stat(8'h00, "R4");
        // R4: write one clears bus error
        wr_stat(8'h20, "R4");
        // R10: set and clear in the same cycle, set wins
        ev_berr = 1; cpu_wr = 1; cpu_sel_stat = 1; cpu_wdata = 8'h20; cyc("R10");
        wr_stat(8'h20, "R4");

        // R3: master, stall enabled, clean address phase
        is_master = 1; ev_addr_sent = 1; cyc("R3");
        cyc("R3");
        wr_stat(8'h08, "R4");
        // R3: address phase with missing acknowledge does not stall
        ev_addr_sent = 1; ev_nak = 1; cyc("R3");
        wr_stat(8'h10, "R4");
        // R3: slave mode never stalls
        is_master = 0; ev_addr_sent = 1; cyc("R3");
        // R7: stall cleared by stall-enable going low
        is_master = 1; ev_addr_sent = 1; cyc("R7");
        stall_en = 0; cyc("R7");
        ev_addr_sent = 1; cyc("R7");
        stall_en = 1;

        // R5: missing acknowledge blocks data-ready in the same cycle
        ev_nak = 1; ev_byte_done = 1; cyc("R5");
        wr_stat(8'h10, "R4");

        // R8: data-ready and its clear rules (receive)
        ev_byte_done = 1; cyc("R8");
        wr_stat(8'h40, "R4");
        start_req = 1; cpu_rd = 1; cpu_sel_data = 1; cyc("R8");
        start_req = 0; cpu_wr = 1; cpu_sel_data = 1; cyc("R8");
        cpu_rd = 1; cpu_sel_data = 1; cyc("R8");
        // R8: transmit mode
        xmit_mode = 1; ev_byte_done = 1; cyc("R8");
        cpu_rd = 1; cpu_sel_data = 1; cyc("R8");
        cpu_wr = 1; cpu_sel_data = 1; cyc("R8");
        xmit_mode = 0;

        // R9: stop without a match
        ev_stop = 1; cyc("R9");
        // R9: matched transfer then stop
        slv_match = 1; cyc("R9");
        slv_match = 0; cyc("R9");
        ev_stop = 1; cyc("R9");
        // R9: match in the same cycle as the stop
        wr_stat(8'h80, "R4");
        slv_match = 1; ev_stop = 1; cyc("R9");
        slv_match = 0;

        // R10: interrupt gating
        irq_en = 0; cyc("R10");
        irq_en = 1; cyc("R10");

        // R6: disable clears everything and blocks events
        ev_berr = 1; ev_addr_sent = 1; cyc("R6");
        mod_en = 0; cyc("R6");
        ev_nak = 1; ev_berr = 1; ev_byte_done = 1; ev_addr_sent = 1; cyc("R6");
        mod_en = 1; cyc("R6");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule